// File: doc/BRIEF.md
# Snooping MESI Coherence Controller for Three Caches

This block joins three single-frame data caches and one shared word memory over a single snooping bus. Each cache has one direct-mapped line frame holding one word plus a full-address tag, so any two addresses contend for the same frame. Every frame is Invalid, Shared, Exclusive or Modified. A processor port on each cache takes load and store requests. Loads and stores that can be served locally complete without using the bus. All other requests compete for the bus through a round-robin arbiter. The bus carries one transaction per cycle: a read, a read-for-ownership, or a writeback of a dirty victim.

The other caches check each bus transaction against their frames. A frame holding the same address raises the shared line and, on a read, downgrades to Shared. A dirty holder also supplies the word in place of memory and writes it back in the same cycle. On a read-for-ownership, every other holder invalidates. A reader that sees the shared line low takes the line as Exclusive, and a later store to it becomes Modified without a bus cycle. Memory words reset to a computed pattern, so reads are checkable without a preload path.

Top module: `mesi_snoop_sys`

## Requirements
- R1: After reset every frame reads Invalid (line state code I=0, S=1, E=2, M=3), no resp_done is high, bus_op is 0 (idle), and memory word a holds (a*37+5) mod 2^DW.
- R2: A load that misses puts a read on the bus (bus_op code 1). It fills Exclusive when bus_shared is low in that cycle and Shared when it is high, and it returns the word supplied.
- R3: Load hits in S, E or M, and store hits in E or M, complete without any bus cycle. A store hit on an Exclusive frame leaves it Modified.
- R4: A store that misses issues a read-for-ownership (bus_op code 2) and fills Modified with the store data. Every other frame holding that address becomes Invalid.
- R5: A store that hits a Shared frame issues a read-for-ownership, ends Modified, and invalidates the other Shared copies.
- R6: When a Modified holder snoops a read for its address, it raises bus_shared, supplies its word instead of memory, writes that word to memory, and becomes Shared. Every load therefore returns the latest stored value for its address.
- R7: A clean holder (E or S) raises bus_shared on a read for its address and ends Shared. Memory supplies the data even though a clean copy exists.
- R8: A request whose frame is Modified with a different address first writes the victim back (bus_op code 3), then performs its own fill. A later load of the victim address returns the evicted word.
- R9: A snooper compares the full address. A frame holding a different address is unaffected and does not raise bus_shared.
- R10: At most one transaction is granted per cycle. Grants rotate round-robin, starting after the last cache granted. A waiting cache keeps its request until it is served.
- R11: A request is taken in the first cycle its cache is idle and sees req_valid. resp_done is a one-cycle pulse with resp_rdata valid. A local hit completes one cycle after acceptance. Acceptance is held off in any cycle in which a bus transaction addresses that cache's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NCACHE | Per-cache request, held until resp_done |
| req_we | input | NCACHE | Per-cache store (1) or load (0) |
| req_addr | input | NCACHE*AW | Per-cache word address |
| req_wdata | input | NCACHE*DW | Per-cache store data |
| resp_done | output | NCACHE | One-cycle completion pulse |
| resp_rdata | output | NCACHE*DW | Load result, valid with resp_done |
| line_state | output | NCACHE*2 | Frame coherence state per cache |
| bus_op | output | 2 | Transaction on the bus this cycle |
| bus_shared | output | 1 | Shared line as seen this cycle |

## Verification
A wrong frame state shows on line_state at the very next clock edge, and usually shows again later. A frame wrongly left Exclusive skips a read-for-ownership, so the bus_op sequence diverges from the reference. A lost Modified copy makes a later load return a stale word at its resp_done. Because the reference model is compared every cycle on line_state, bus_op, bus_shared and resp_done, most faults are flagged within one cycle of the transaction that caused them. Stale data is flagged at the first load of that address afterwards.

// File: rtl/mesi_pkg.sv
// Shared types for the snooping coherence system.
// Assumes: two-bit encodings are visible at the top ports, so values are fixed.
package mesi_pkg;
    typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
    typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_RDX = 2'd2, OP_WB = 2'd3} bus_op_t;
    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_BUS = 2'd1, PH_RESP = 2'd2} phase_t;
endpackage

// File: rtl/mesi_rr_arb.sv
// Round-robin bus arbiter: grants one requester per cycle, searching from the
// slot after the last winner. Assumes requests come from registered state.
module mesi_rr_arb #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr_q;

    // Pick the first requester at or after the pointer.
    always_comb begin
        grant     = '0;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < N; k++) begin
            int slot;
            slot = int'(ptr_q) + k;
            if (slot >= N) slot = slot - N;
            if (!gnt_valid && req[slot]) begin
                gnt_valid   = 1'b1;
                gnt_idx     = IW'(slot);
                grant[slot] = 1'b1;
            end
        end
    end

    // Advance the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr_q <= '0;
        else if (gnt_valid) ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
    end

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

    for (genvar i = 0; i < N; i++) begin : g_hold
        // R10
        req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !grant[i]) |=> req[i]);
    end
endmodule

// File: rtl/mesi_word_mem.sv
// Word-addressed backing memory with one combinational read and one write port.
// Assumes: the bus issues at most one write per cycle (writeback or flush).
module mesi_word_mem #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    // Reset to a computed pattern, otherwise take the bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= DW'(a * 37 + 5);
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    // Asynchronous read of the addressed word.
    assign rdata = mem_q[addr];
endmodule

// File: rtl/mesi_cache.sv
// One single-frame MESI cache: processor-side FSM plus snoop response.
// Assumes: only one bus transaction per cycle, and grant and snoop are never
// both active for this cache in the same cycle.
module mesi_cache
    import mesi_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          resp_done,
    output logic [DW-1:0] resp_rdata,
    output line_st_t      line_state,
    output logic [AW-1:0] line_tag,
    output logic          bus_req,
    input  logic          bus_grant,
    output bus_op_t       my_op,
    output logic [AW-1:0] my_addr,
    output logic [DW-1:0] my_data,
    input  logic          bus_valid,
    input  bus_op_t       bus_op_in,
    input  logic [AW-1:0] bus_addr_in,
    input  logic [DW-1:0] fill_data,
    input  logic          fill_shared,
    output logic          snoop_hit,
    output logic          snoop_flush
);
    line_st_t      st_q;
    phase_t        ph_q;
    logic [AW-1:0] tag_q, p_addr;
    logic [DW-1:0] data_q, p_wdata, rdata_q;
    logic          p_we, local_hit, snoop_match;

    assign local_hit   = (st_q != ST_I) && (tag_q == req_addr);
    assign snoop_match = bus_valid && !bus_grant && (bus_op_in != OP_WB)
                         && (st_q != ST_I) && (tag_q == bus_addr_in);
    assign snoop_hit   = snoop_match;
    assign snoop_flush = snoop_match && (st_q == ST_M);
    assign bus_req     = (ph_q == PH_BUS);
    assign resp_done   = (ph_q == PH_RESP);
    assign resp_rdata  = rdata_q;
    assign line_state  = st_q;
    assign line_tag    = tag_q;
    assign my_data     = data_q;

    // Choose the bus operation: evict a dirty victim first, then fill.
    always_comb begin
        if (st_q == ST_M && tag_q != p_addr) begin
            my_op   = OP_WB;
            my_addr = tag_q;
        end else begin
            my_op   = p_we ? OP_RDX : OP_RD;
            my_addr = p_addr;
        end
    end

    // Frame, request and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_I;
            ph_q    <= PH_IDLE;
            tag_q   <= '0;
            data_q  <= '0;
            p_we    <= 1'b0;
            p_addr  <= '0;
            p_wdata <= '0;
            rdata_q <= '0;
        end else begin
            if (snoop_match) st_q <= (bus_op_in == OP_RD) ? ST_S : ST_I;
            case (ph_q)
                PH_IDLE: if (req_valid && !snoop_match) begin
                    p_we    <= req_we;
                    p_addr  <= req_addr;
                    p_wdata <= req_wdata;
                    if (local_hit && !req_we) begin
                        rdata_q <= data_q;
                        ph_q    <= PH_RESP;
                    end else if (local_hit && (st_q == ST_E || st_q == ST_M)) begin
                        data_q  <= req_wdata;
                        st_q    <= ST_M;
                        rdata_q <= req_wdata;
                        ph_q    <= PH_RESP;
                    end else begin
                        ph_q <= PH_BUS;
                    end
                end
                PH_BUS: if (bus_grant) begin
                    case (my_op)
                        OP_WB: st_q <= ST_I;
                        OP_RD: begin
                            tag_q   <= p_addr;
                            data_q  <= fill_data;
                            rdata_q <= fill_data;
                            st_q    <= fill_shared ? ST_S : ST_E;
                            ph_q    <= PH_RESP;
                        end
                        default: begin
                            tag_q   <= p_addr;
                            data_q  <= p_wdata;
                            rdata_q <= p_wdata;
                            st_q    <= ST_M;
                            ph_q    <= PH_RESP;
                        end
                    endcase
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R2
    fill_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && my_op == OP_RD && !fill_shared) |=> (st_q == ST_E));
    // R3
    silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE && req_valid && req_we && st_q == ST_E && tag_q == req_addr && !snoop_match)
        |=> (st_q == ST_M && ph_q == PH_RESP));
    // R6
    flush_to_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_match && bus_op_in == OP_RD && st_q == ST_M) |=> (st_q == ST_S));
    // R8
    victim_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && my_op == OP_WB) |=> (st_q == ST_I && ph_q == PH_BUS));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);
endmodule

// File: rtl/mesi_snoop_sys.sv
// Top: three single-frame MESI caches, round-robin bus, shared word memory.
// Assumes: each processor holds req_valid until its resp_done pulse.
module mesi_snoop_sys
    import mesi_pkg::*;
#(
    parameter int NCACHE = 3,
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int IW = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCACHE-1:0]    req_valid,
    input  logic [NCACHE-1:0]    req_we,
    input  logic [NCACHE*AW-1:0] req_addr,
    input  logic [NCACHE*DW-1:0] req_wdata,
    output logic [NCACHE-1:0]    resp_done,
    output logic [NCACHE*DW-1:0] resp_rdata,
    output logic [NCACHE*2-1:0]  line_state,
    output logic [1:0]           bus_op,
    output logic                 bus_shared
);
    logic [NCACHE-1:0] c_req, c_grant, c_hit, c_flush;
    bus_op_t           c_op   [NCACHE];
    logic [AW-1:0]     c_addr [NCACHE];
    logic [AW-1:0]     c_tag  [NCACHE];
    logic [DW-1:0]     c_data [NCACHE];
    line_st_t          c_st   [NCACHE];
    logic              gnt_valid, mem_we, owner_conflict;
    logic [IW-1:0]     gnt_idx;
    bus_op_t           sel_op;
    logic [AW-1:0]     sel_addr;
    logic [DW-1:0]     wb_data, flush_data, mem_rdata, fill_data;

    mesi_rr_arb #(.N(NCACHE)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(c_req), .grant(c_grant),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    for (genvar c = 0; c < NCACHE; c++) begin : g_cache
        mesi_cache #(.AW(AW), .DW(DW)) u_cache (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid[c]), .req_we(req_we[c]),
            .req_addr(req_addr[c*AW +: AW]), .req_wdata(req_wdata[c*DW +: DW]),
            .resp_done(resp_done[c]), .resp_rdata(resp_rdata[c*DW +: DW]),
            .line_state(c_st[c]), .line_tag(c_tag[c]),
            .bus_req(c_req[c]), .bus_grant(c_grant[c]),
            .my_op(c_op[c]), .my_addr(c_addr[c]), .my_data(c_data[c]),
            .bus_valid(gnt_valid), .bus_op_in(sel_op), .bus_addr_in(sel_addr),
            .fill_data(fill_data), .fill_shared(bus_shared),
            .snoop_hit(c_hit[c]), .snoop_flush(c_flush[c])
        );
        assign line_state[c*2 +: 2] = c_st[c];
    end

    // Steer the winner onto the bus and gather snoop replies.
    always_comb begin
        sel_op     = OP_NONE;
        sel_addr   = '0;
        wb_data    = '0;
        flush_data = '0;
        for (int c = 0; c < NCACHE; c++) begin
            if (c_grant[c]) begin
                sel_op   = c_op[c];
                sel_addr = c_addr[c];
                wb_data  = c_data[c];
            end
            if (c_flush[c]) flush_data = flush_data | c_data[c];
        end
    end

    assign bus_shared = |c_hit;
    assign bus_op     = sel_op;
    assign mem_we     = (sel_op == OP_WB) || (|c_flush);
    assign fill_data  = (|c_flush) ? flush_data : mem_rdata;

    mesi_word_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .addr(sel_addr), .we(mem_we),
        .wdata((sel_op == OP_WB) ? wb_data : flush_data), .rdata(mem_rdata)
    );

    // Flag any Modified frame whose address is also valid elsewhere.
    always_comb begin
        owner_conflict = 1'b0;
        for (int i = 0; i < NCACHE; i++)
            for (int j = 0; j < NCACHE; j++)
                if (i != j && c_st[i] == ST_M && c_st[j] != ST_I && c_tag[i] == c_tag[j])
                    owner_conflict = 1'b1;
    end

    // R4
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n) !owner_conflict);
    // R6
    one_flusher_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(c_flush));
    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req == '0) |-> (bus_op == OP_NONE));
endmodule

// File: tb/sim_mesi_snoop_sys.sv
module sim_mesi_snoop_sys;
    localparam int N = 3, AW = 4, DW = 8, DEPTH = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] req_valid = '0, req_we = '0, resp_done;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_wdata = '0, resp_rdata;
    logic [N*2-1:0] line_state;
    logic [1:0] bus_op;
    logic bus_shared;

    always #4 clk = ~clk;

    mesi_snoop_sys u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_done(resp_done),
        .resp_rdata(resp_rdata), .line_state(line_state), .bus_op(bus_op),
        .bus_shared(bus_shared));

    int tests = 0, fails = 0, cyc = 0, busops = 0;
    bit timeout = 0;
    // reference model: states I0 S1 E2 M3, phases idle0 bus1 resp2
    int mst[N], mtag[N], mdat[N], mph[N], pa[N], pw[N], pd[N], mrd[N];
    int mem[DEPTH], gold[DEPTH], ptr;
    logic [12:0] opq[N][$];
    bit act[N];
    int cur[N], last_rd[N], done_cyc[N];

    task automatic check(input bit ok, input string tag, input int actv, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, actv, expv, cyc);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < N; c++) begin
            mst[c] = 0; mtag[c] = 0; mdat[c] = 0; mph[c] = 0;
            pa[c] = 0; pw[c] = 0; pd[c] = 0; mrd[c] = 0; act[c] = 0;
        end
        for (int a = 0; a < DEPTH; a++) begin
            mem[a] = (a * 37 + 5) % 256; gold[a] = mem[a];
        end
        ptr = 0;
    endtask

    task automatic step();
        int g, op, flusher, fill;
        bit shared;
        bit match[N];
        int nst[N], ntag[N], ndat[N], nph[N], nrd[N];
        @(negedge clk);
        // registered outputs against the model
        for (int c = 0; c < N; c++) begin
            check(line_state[c*2 +: 2] == 2'(mst[c]), "R2 line state", line_state[c*2 +: 2], mst[c]);
            check(resp_done[c] == (mph[c] == 2), "R11 done", resp_done[c], mph[c] == 2);
            if (mph[c] == 2)
                check(resp_rdata[c*DW +: DW] == 8'(mrd[c]), "R2 rdata", resp_rdata[c*DW +: DW], mrd[c]);
        end
        // processor agents
        for (int c = 0; c < N; c++) begin
            if (act[c] && resp_done[c]) begin
                if (!cur[c][12]) begin
                    check(int'(resp_rdata[c*DW +: DW]) == gold[cur[c][11:8]], "R6 coherent load",
                          resp_rdata[c*DW +: DW], gold[cur[c][11:8]]);
                    last_rd[c] = resp_rdata[c*DW +: DW];
                end else gold[cur[c][11:8]] = cur[c][7:0];
                act[c] = 0; req_valid[c] = 1'b0; done_cyc[c] = cyc;
            end else if (!act[c] && opq[c].size() > 0) begin
                cur[c] = int'(opq[c].pop_front());
                act[c] = 1;
                req_valid[c] = 1'b1;
                req_we[c] = cur[c][12];
                req_addr[c*AW +: AW] = 4'(cur[c][11:8]);
                req_wdata[c*DW +: DW] = 8'(cur[c][7:0]);
            end
        end
        #1;
        // bus cycle of the model
        g = -1;
        for (int k = 0; k < N; k++) if (g < 0 && mph[(ptr + k) % N] == 1) g = (ptr + k) % N;
        op = 0; shared = 0; flusher = -1;
        if (g >= 0) op = (mst[g] == 3 && mtag[g] != pa[g]) ? 3 : (pw[g] ? 2 : 1);
        for (int c = 0; c < N; c++) begin
            match[c] = (g >= 0) && (c != g) && (op != 3) && (mst[c] != 0) && (mtag[c] == pa[g]);
            if (match[c]) begin shared = 1; if (mst[c] == 3) flusher = c; end
        end
        check(bus_op == 2'(op), "R10 bus op", bus_op, op);
        check(bus_shared == shared, "R7 shared", bus_shared, shared);
        if (op != 0) busops++;
        fill = (g >= 0) ? ((flusher >= 0) ? mdat[flusher] : mem[pa[g]]) : 0;
        for (int c = 0; c < N; c++) begin
            nst[c] = mst[c]; ntag[c] = mtag[c]; ndat[c] = mdat[c]; nph[c] = mph[c]; nrd[c] = mrd[c];
            if (match[c]) nst[c] = (op == 1) ? 1 : 0;
            if (mph[c] == 0 && req_valid[c] && !match[c]) begin
                int a, w, d;
                bit hit;
                a = req_addr[c*AW +: AW]; w = req_we[c]; d = req_wdata[c*DW +: DW];
                pa[c] = a; pw[c] = w; pd[c] = d;
                hit = (mst[c] != 0) && (mtag[c] == a);
                if (hit && !w) begin nrd[c] = mdat[c]; nph[c] = 2; end
                else if (hit && mst[c] >= 2) begin ndat[c] = d; nst[c] = 3; nrd[c] = d; nph[c] = 2; end
                else nph[c] = 1;
            end else if (mph[c] == 1 && c == g) begin
                if (op == 3) nst[c] = 0;
                else begin
                    ntag[c] = pa[c];
                    ndat[c] = (op == 1) ? fill : pd[c];
                    nrd[c] = ndat[c];
                    nst[c] = (op == 2) ? 3 : (shared ? 1 : 2);
                    nph[c] = 2;
                end
            end else if (mph[c] == 2) nph[c] = 0;
        end
        if (op == 3) mem[mtag[g]] = mdat[g];
        else if (flusher >= 0) mem[pa[g]] = mdat[flusher];
        if (g >= 0) ptr = (g + 1) % N;
        for (int c = 0; c < N; c++) begin
            mst[c] = nst[c]; mtag[c] = ntag[c]; mdat[c] = ndat[c]; mph[c] = nph[c]; mrd[c] = nrd[c];
        end
        cyc++;
        if (cyc > 150000) timeout = 1;
    endtask

    task automatic push(input int c, input bit we, input int a, input int d);
        opq[c].push_back({we, 4'(a), 8'(d)});
    endtask

    task automatic run();
        bit busy;
        do begin
            step();
            busy = 0;
            for (int c = 0; c < N; c++) if (act[c] || opq[c].size() > 0 || mph[c] != 0) busy = 1;
        end while (busy && !timeout);
        step();
    endtask

    function automatic int st(input int c);
        return int'(line_state[c*2 +: 2]);
    endfunction

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int c = 0; c < N; c++) check(st(c) == 0, "R1 frame invalid", st(c), 0);
        check(resp_done == '0, "R1 no done", resp_done, 0);
        check(bus_op == 2'd0, "R1 bus idle", bus_op, 0);
        // R2 read miss alone -> E, init pattern
        push(0, 0, 5, 0); run();
        check(st(0) == 2, "R2 fill E", st(0), 2);
        check(last_rd[0] == 190, "R1 memory pattern", last_rd[0], 190);
        // R7 clean holder shares
        push(1, 0, 5, 0); run();
        check(st(1) == 1, "R7 reader S", st(1), 1);
        check(st(0) == 1, "R7 holder E to S", st(0), 1);
        // R5 store hit on S
        push(0, 1, 5, 8'h3C); run();
        check(st(0) == 3, "R5 upgrade M", st(0), 3);
        check(st(1) == 0, "R5 other invalid", st(1), 0);
        // R6 dirty holder flushes
        push(2, 0, 5, 0); run();
        check(last_rd[2] == 8'h3C, "R6 flushed word", last_rd[2], 8'h3C);
        check(st(0) == 1 && st(2) == 1, "R6 both S", st(0) * 4 + st(2), 5);
        // R3 silent E to M
        busops = 0;
        push(1, 0, 9, 0); push(1, 1, 9, 8'h77); run();
        check(busops == 1, "R3 bus ops", busops, 1);
        check(st(1) == 3, "R3 E to M", st(1), 3);
        // R8 dirty victim writeback
        busops = 0;
        push(1, 1, 3, 8'h55); run();
        check(busops == 2, "R8 wb plus fill", busops, 2);
        push(0, 0, 9, 0); run();
        check(last_rd[0] == 8'h77, "R8 victim in memory", last_rd[0], 8'h77);
        check(st(0) == 2, "R8 reader E", st(0), 2);
        // R4 store miss invalidates holder
        push(2, 1, 9, 8'h12); run();
        check(st(2) == 3, "R4 fill M", st(2), 3);
        check(st(0) == 0, "R4 holder invalid", st(0), 0);
        // R9 different tag untouched
        push(0, 0, 11, 0); run();
        check(st(0) == 2, "R9 no shared", st(0), 2);
        check(st(1) == 3 && st(2) == 3, "R9 others kept", st(1) * 4 + st(2), 15);
        // R10 simultaneous requests serialized
        push(0, 0, 13, 0); push(1, 0, 14, 0); push(2, 0, 15, 0); run();
        check(done_cyc[0] != done_cyc[1] && done_cyc[1] != done_cyc[2] && done_cyc[0] != done_cyc[2],
              "R10 distinct completions", done_cyc[0], -1);
        // mixed traffic on a few addresses
        for (int i = 0; i < 200; i++)
            for (int c = 0; c < N; c++) push(c, 1'($urandom_range(1)), $urandom_range(3), $urandom_range(255));
        run();
        check(!timeout, "R11 progress", timeout, 0);
        if (timeout) begin tests++; fails++; $display("FAIL R11 watchdog: actual 1 expected 0"); end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule